// File: doc/BRIEF.md
# Serial Identity-Code CRC Checker

This block checks a 64-bit device identity code that arrives one bit at a time, least-significant bit first. The code is made of an 8-bit family byte, a 48-bit serial number and a trailing 8-bit check byte. A bit-serial CRC register with XOR feedback absorbs each accepted bit. After the first 56 bits the register holds the check value for the family and serial fields. After all 64 bits it holds zero when the stored check byte agrees.

The same engine also serves a scratchpad read. In that mode, eight data bytes followed by their check byte (72 bits in all) are run through the register, and a zero residue again means the transfer is intact. The block only reports its result. A mismatch never stalls the bit stream or withholds `done`. The caller decides what to do next.

The caller pulses `clear` before each frame. The frame type is taken from `modeScratch` in the cycle `clear` is high. The caller then presents bits with `bitValid`. Once the frame length has been reached, `done` goes high and `match` is valid. `familyOk` reports whether the first byte of an identity code equals the expected family value.

Top module: `crc_rom_checker`

## Requirements
- R1: After reset, `crcValue` is 0, and `done`, `match` and `familyOk` are low.
- R2: Each accepted bit updates the register as follows. Let f be `bitIn` XOR register bit 0. The register shifts right by one, and if f is 1 the result is XORed with 8'h8C (polynomial x^8+x^5+x^4+1, bit-reversed form). The new value appears on `crcValue` one cycle after the bit.
- R3: In a cycle with neither `clear` nor `bitValid`, `crcValue`, `done` and `familyOk` keep their values.
- R4: One cycle after `clear`, `crcValue` is 0 and `done`, `match` and `familyOk` are low. `clear` takes priority over a simultaneous `bitValid`. The frame type is captured from `modeScratch` in the `clear` cycle (0 = identity code of 64 bits, 1 = scratchpad of 72 bits).
- R5: In identity mode, `done` rises one cycle after the 64th accepted bit and is low before that.
- R6: In scratchpad mode, `done` rises one cycle after the 72nd accepted bit and is still low after 64 bits.
- R7: Bits presented while `done` is high are ignored: `crcValue`, `done` and `match` do not change.
- R8: `match` is high exactly when `done` is high and the register is zero. A frame whose last byte is the CRC of the preceding bits gives `match` = 1.
- R9: After the first 56 bits of an identity code, `crcValue` equals the CRC of those 56 bits.
- R10: In identity mode, `familyOk` is high once at least 8 bits have been accepted and the first 8 bits, with the first bit as bit 0, equal 8'h28. It is low before 8 bits, and always low in scratchpad mode.
- R11: A corrupted frame still completes. `done` rises at the normal bit count with `match` low, and after a `clear` the next frame is processed normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Start a new frame; zeroes the register and the count |
| modeScratch | input | 1 | Frame type, sampled with `clear` (1 = 72-bit scratchpad) |
| bitValid | input | 1 | `bitIn` carries a frame bit this cycle |
| bitIn | input | 1 | Serial data bit, LSB first |
| crcValue | output | 8 | Current CRC register contents |
| done | output | 1 | Full frame received |
| match | output | 1 | Frame complete with zero residue |
| familyOk | output | 1 | Family byte equals the expected code (identity mode) |

## Verification
A wrong tap or feedback bit in the CRC register shows on `crcValue` one cycle after the first bit that exercises it. A sweep over all 256 first bytes therefore exposes any single tap error within eight bits. A miscounting bit counter shows at the frame boundary: `done` rises a cycle early or late, and `match` no longer agrees with the residue. A stale mode or family latch shows as a `familyOk` or `done` value that is wrong for the frame type chosen at the last `clear`.

// File: rtl/crc_rom_pkg.sv
package crc_rom_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic zero;      // reset CRC and family latch
    logic shift;     // absorb bitIn into CRC
    logic famShift;  // absorb bitIn into family latch
  } crcCtl_t;
endpackage

// File: rtl/crc_rom_ctl.sv
module crc_rom_ctl
  import crc_rom_pkg::*;
#(
  parameter int ID_BITS  = 64,
  parameter int PAD_BITS = 72,
  parameter int FAM_BITS = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    clear,
  input  logic    modeScratch,
  input  logic    bitValid,
  output crcCtl_t ctl,
  output logic    done,
  output logic    scratch,
  output logic    famSeen
);
  localparam int CNT_W = $clog2(PAD_BITS + 1);

  logic [CNT_W-1:0] bitCount;
  logic [CNT_W-1:0] frameLen;

  assign frameLen = scratch ? CNT_W'(PAD_BITS) : CNT_W'(ID_BITS);
  assign done     = (bitCount == frameLen);
  assign famSeen  = (bitCount >= CNT_W'(FAM_BITS));

  always_comb begin
    ctl          = '0;
    ctl.zero     = clear;
    ctl.shift    = bitValid && !clear && !done;
    ctl.famShift = ctl.shift && !famSeen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
      scratch  <= 1'b0;
    end else if (clear) begin
      bitCount <= '0;
      scratch  <= modeScratch;
    end else if (ctl.shift) begin
      bitCount <= bitCount + 1'b1;
    end
  end
endmodule

// File: rtl/crc_rom_dp.sv
module crc_rom_dp
  import crc_rom_pkg::*;
#(
  parameter int          CRC_W    = 8,
  parameter logic [7:0]  POLY_REV = 8'h8C,
  parameter int          FAM_BITS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  crcCtl_t          ctl,
  input  logic             bitIn,
  output logic [CRC_W-1:0] crcReg,
  output logic [FAM_BITS-1:0] famReg
);
  logic             feedback;
  logic [CRC_W-1:0] crcNext;

  assign feedback = crcReg[0] ^ bitIn;

  // shift right, then apply the taps where feedback is set
  always_comb begin
    crcNext = crcReg >> 1;
    for (int i = 0; i < CRC_W; i++) begin
      if (POLY_REV[i]) crcNext[i] = crcNext[i] ^ feedback;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg <= '0;
      famReg <= '0;
    end else if (ctl.zero) begin
      crcReg <= '0;
      famReg <= '0;
    end else begin
      if (ctl.shift)    crcReg <= crcNext;
      if (ctl.famShift) famReg <= {bitIn, famReg[FAM_BITS-1:1]};
    end
  end
endmodule

// File: rtl/crc_rom_checker.sv
module crc_rom_checker
  import crc_rom_pkg::*;
#(
  parameter int         ID_BITS  = 64,
  parameter int         PAD_BITS = 72,
  parameter int         FAM_BITS = 8,
  parameter logic [7:0] FAMILY   = 8'h28,
  parameter logic [7:0] POLY_REV = 8'h8C
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clear,
  input  logic       modeScratch,
  input  logic       bitValid,
  input  logic       bitIn,
  output logic [7:0] crcValue,
  output logic       done,
  output logic       match,
  output logic       familyOk
);
  crcCtl_t             ctl;
  logic                scratch;
  logic                famSeen;
  logic [FAM_BITS-1:0] famReg;

  crc_rom_ctl #(.ID_BITS(ID_BITS), .PAD_BITS(PAD_BITS), .FAM_BITS(FAM_BITS)) i_ctl (
    .clk(clk), .rstN(rstN), .clear(clear), .modeScratch(modeScratch),
    .bitValid(bitValid), .ctl(ctl), .done(done), .scratch(scratch), .famSeen(famSeen)
  );

  crc_rom_dp #(.CRC_W(8), .POLY_REV(POLY_REV), .FAM_BITS(FAM_BITS)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bitIn(bitIn), .crcReg(crcValue), .famReg(famReg)
  );

  assign match    = done && (crcValue == '0);
  assign familyOk = famSeen && !scratch && (famReg == FAMILY[FAM_BITS-1:0]);
endmodule

// File: rtl/crc_rom_sva.sv
module crc_rom_sva #(
  parameter int ID_BITS  = 64,
  parameter int PAD_BITS = 72
) (
  input logic       clk,
  input logic       rstN,
  input logic       clear,
  input logic       bitValid,
  input logic [7:0] crcValue,
  input logic       done,
  input logic       match,
  input logic       familyOk
);
  logic [7:0] chkCount;  // accepted bits since the last clear

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            chkCount <= '0;
    else if (clear)                       chkCount <= '0;
    else if (bitValid && !done)           chkCount <= chkCount + 1'b1;
  end

  AST_CLEAR_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (crcValue == 8'h00 && !done && !match && !familyOk));  // R4
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && !bitValid) |=> ($stable(crcValue) && $stable(done)));  // R3
  AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (done && !clear) |=> (done && $stable(crcValue) && $stable(match)));  // R7
  AST_MATCH_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    match |-> done);  // R8
  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (chkCount == 8'(ID_BITS) || chkCount == 8'(PAD_BITS)));  // R5
  AST_FAMILY_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    familyOk |-> (chkCount >= 8'd8));  // R10
endmodule

bind crc_rom_checker crc_rom_sva #(.ID_BITS(ID_BITS), .PAD_BITS(PAD_BITS)) i_sva (
  .clk(clk), .rstN(rstN), .clear(clear), .bitValid(bitValid), .crcValue(crcValue),
  .done(done), .match(match), .familyOk(familyOk)
);

// File: tb/test_crc_rom_checker.sv
module test_crc_rom_checker;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clear = 1'b0;
  logic       modeScratch = 1'b0;
  logic       bitValid = 1'b0;
  logic       bitIn = 1'b0;
  logic [7:0] crcValue;
  logic       done, match, familyOk;
  int         nVec = 0;
  int         nBad = 0;

  always #10 clk = ~clk;  // 50 MHz

  crc_rom_checker i_crc_rom_checker (
    .clk(clk), .rstN(rstN), .clear(clear), .modeScratch(modeScratch),
    .bitValid(bitValid), .bitIn(bitIn), .crcValue(crcValue),
    .done(done), .match(match), .familyOk(familyOk)
  );

  function automatic logic [7:0] refCrc(input logic [71:0] v, input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      logic f = c[0] ^ v[i];
      c = c >> 1;
      if (f) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic doClear(input logic mode);
    @(negedge clk); clear = 1'b1; modeScratch = mode;
    @(negedge clk); clear = 1'b0; modeScratch = 1'b0;
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk); bitValid = 1'b1; bitIn = b;
    @(negedge clk); bitValid = 1'b0; bitIn = 1'b0;
  endtask

  task automatic sendBits(input logic [71:0] v, input int from, input int to);
    for (int i = from; i < to; i++) sendBit(v[i]);
  endtask

  // one identity frame: family byte + 48-bit serial + crc (optionally corrupted)
  task automatic runId(input logic [7:0] fam, input logic [47:0] ser, input logic [7:0] flip);
    logic [71:0] v;
    logic [7:0]  c;
    v = '0;
    v[55:0] = {ser, fam};
    c = refCrc(v, 56);
    v[63:56] = c ^ flip;
    doClear(1'b0);
    sendBits(v, 0, 7);
    check("R10 familyOk before 8 bits", {7'd0, familyOk}, 8'd0);
    sendBits(v, 7, 8);
    check("R10 familyOk after byte", {7'd0, familyOk}, {7'd0, fam == 8'h28});
    sendBits(v, 8, 56);
    check("R9 crc over 56 bits", crcValue, c);
    sendBits(v, 56, 63);
    check("R5 done low before 64", {7'd0, done}, 8'd0);
    sendBits(v, 63, 64);
    check("R5 done after 64", {7'd0, done}, 8'd1);
    check("R8/R11 match", {7'd0, match}, {7'd0, flip == 8'h00});
    check("R2 residue", crcValue, refCrc(v, 64));
  endtask

  initial begin
    #(20 * 150000);
    nBad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    logic [71:0] v;
    logic [7:0]  held;
    repeat (3) @(negedge clk);
    check("R1 reset crc", crcValue, 8'h00);
    check("R1 reset flags", {5'd0, done, match, familyOk}, 8'h00);
    rstN = 1'b1;

    // R2: every first byte, compared bit by bit
    for (int b = 0; b < 256; b++) begin
      doClear(1'b0);
      v = 72'(b);
      for (int i = 0; i < 8; i++) begin
        sendBit(v[i]);
        check("R2 per-bit update", crcValue, refCrc(v, i + 1));
      end
    end

    // identity frames: valid, wrong family, corrupted
    runId(8'h28, 48'h0000_0000_0001, 8'h00);
    runId(8'h28, 48'hA5C3_1F09_7E42, 8'h00);
    runId(8'h10, 48'hFFFF_FFFF_FFFF, 8'h00);
    runId(8'h28, 48'h1234_5678_9ABC, 8'h01);  // R11 corrupted
    runId(8'h29, 48'h8000_0000_0000, 8'h80);

    // R7: bits after done ignored
    held = crcValue;
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    check("R7 crc frozen after done", crcValue, held);
    check("R7 done held", {7'd0, done}, 8'd1);

    // R11: next frame after clear works
    runId(8'h28, 48'h0F0F_0F0F_0F0F, 8'h00);

    // R3: idle cycles hold
    doClear(1'b0);
    v = 72'h5A_3C;
    sendBits(v, 0, 5);
    held = crcValue;
    repeat (4) @(negedge clk);
    check("R3 idle hold", crcValue, held);
    check("R3 idle done", {7'd0, done}, 8'd0);

    // R4: clear beats a simultaneous bit
    @(negedge clk); clear = 1'b1; bitValid = 1'b1; bitIn = 1'b1;
    @(negedge clk); clear = 1'b0; bitValid = 1'b0; bitIn = 1'b0;
    check("R4 clear priority crc", crcValue, 8'h00);
    check("R4 clear flags", {5'd0, done, match, familyOk}, 8'h00);

    // R6: scratchpad frames, 8 data bytes + crc
    for (int k = 0; k < 3; k++) begin
      v = '0;
      v[63:0] = 64'h28C3_0A11_FE00_7F55 * (k + 3);
      v[71:64] = refCrc(v, 64) ^ ((k == 2) ? 8'h04 : 8'h00);
      doClear(1'b1);
      sendBits(v, 0, 64);
      check("R6 done low at 64", {7'd0, done}, 8'd0);
      check("R10 familyOk low in scratchpad", {7'd0, familyOk}, 8'd0);
      sendBits(v, 64, 72);
      check("R6 done at 72", {7'd0, done}, 8'd1);
      check("R8 scratch match", {7'd0, match}, {7'd0, k != 2});
    end

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule